// File: doc/BRIEF.md
# Banked Address Decoder for a Game Board Processor

This block turns the 16-bit address bus of the main processor on a small arcade board into one-hot chip selects for work RAM, the sprite engine, two zoom/rotate graphics engines, palette RAM and the program ROMs. It also holds two write-only control registers. The bank register chooses which 16 KiB page of the large program ROM appears in the switched window. It also chooses whether two low RAM windows show plain RAM or the first zoom engine and the palette. The video register drives the two coin counters. It can also turn read accesses to either zoom engine into raw graphics-ROM readback, for self-test.

Writes to a few fixed addresses produce single-cycle strobes for the sound command latch, the sound processor interrupt and the watchdog. The memories and peripherals themselves sit outside the block. A read that hits no device raises a flag so that the board can return 0xFF on the data bus.

Top module: `board_addr_decoder`

## Requirements
- R1: After reset both control registers hold 0x00: the coin counters are low, 0x1000–0x1FFF selects plain RAM, and a read at 0x4000 gives ROM address 0x10000.
- R2: Any access to 0x0000–0x0FFF selects work RAM (index 0). A read of 0x8000–0xFFFF selects fixed ROM (index 11).
- R3: A write to 0x3002 loads the bank register. A read of 0x4000–0x7FFF selects banked ROM (index 10), and romAddr equals 0x10000 + bank × 0x4000 + (address & 0x3FFF), where the bank is register bits 4:0.
- R4: With bank register bit 5 at 1, 0x1000–0x17FF selects zoom engine A (index 3) and 0x1800–0x1FFF selects palette RAM (index 4). With bit 5 at 0 they select plain RAM windows A (index 1) and B (index 2).
- R5: A write to 0x3003 loads the video register. With its bit 4 at 1, a read of a zoom engine window selects that engine's ROM readback path instead: index 8 for engine A, index 9 for engine B. Writes still select the engine port.
- R6: Video register bit 0 drives coinCount[1] and bit 1 drives coinCount[0], from the clock edge that loads the register.
- R7: A write to 0x3000 pulses sndLatchWr and a write to 0x3001 pulses sndIrqPulse in the same cycle. Reads of these addresses pulse neither.
- R8: A write to 0x3300 pulses wdogKick in the same cycle, and no other access does.
- R9: 0x2000–0x2007 selects the sprite registers (index 5), 0x2400–0x27FF selects sprite RAM (index 6), and 0x2800–0x2FFF selects zoom engine B (index 7).
- R10: An address outside all windows selects nothing, and so does a write to either ROM window. A read that selects nothing raises openBusEn, which tells the board to return 0xFF.
- R11: At most one chip select is high at a time, and none is high while neither strobe is active. A write strobe takes priority over a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Processor address |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data byte |
| chipSel | output | 12 | One-hot device selects (indices as in the requirements) |
| romAddr | output | 20 | Physical program-ROM address for the switched window |
| sndLatchWr | output | 1 | Sound command latch write strobe |
| sndIrqPulse | output | 1 | Sound processor interrupt trigger |
| wdogKick | output | 1 | Watchdog restart pulse |
| coinCount | output | 2 | Coin counter drives |
| openBusEn | output | 1 | Read of an unmapped address; board returns 0xFF |

## Verification
A wrong value in the bank register shows up in the first read of the switched ROM window, as a wrong page in romAddr bits 19:14. A wrong bit 5 swaps plain RAM for the zoom engine or palette on the next access to 0x1000–0x1FFF. A stale video register shows at once on the coin counter pins. It also shows on the next read of either zoom window, which selects the ROM path when it should select the engine port, or the reverse. Every register effect is therefore visible at the ports one cycle after the loading write. The bench sweeps the address space under all four combinations of the two routing bits.

// File: rtl/mapdec_pkg.sv
package mapdec_pkg;

  typedef enum logic [3:0] {
    RG_NONE,
    RG_WRAM,
    RG_WIN_A,
    RG_WIN_B,
    RG_SPR_REG,
    RG_SPR_RAM,
    RG_ZOOM_B,
    RG_BANK_ROM,
    RG_FIX_ROM
  } region_e;

  typedef struct packed {
    logic loadBank;
    logic loadVideo;
    logic sndCmd;
    logic sndIrq;
    logic wdogKick;
  } strobe_t;

  localparam int CS_WRAM      = 0;
  localparam int CS_RAM_A     = 1;
  localparam int CS_RAM_B     = 2;
  localparam int CS_ZOOM_A    = 3;
  localparam int CS_PALETTE   = 4;
  localparam int CS_SPR_REG   = 5;
  localparam int CS_SPR_RAM   = 6;
  localparam int CS_ZOOM_B    = 7;
  localparam int CS_ZROM_A    = 8;
  localparam int CS_ZROM_B    = 9;
  localparam int CS_BANK_ROM  = 10;
  localparam int CS_FIX_ROM   = 11;
  localparam int NUM_CS       = 12;

  localparam logic [15:0] ADR_SND_CMD  = 16'h3000;
  localparam logic [15:0] ADR_SND_IRQ  = 16'h3001;
  localparam logic [15:0] ADR_BANK_REG = 16'h3002;
  localparam logic [15:0] ADR_VID_REG  = 16'h3003;
  localparam logic [15:0] ADR_WDOG     = 16'h3300;

  localparam int WIN_SWAP_BIT = 5;
  localparam int ROM_READ_BIT = 4;

endpackage

// File: rtl/map_ctrl.sv
module map_ctrl
  import mapdec_pkg::*;
(
  input  logic [15:0] addr,
  input  logic        rdEn,
  input  logic        wrEn,
  output region_e     region,
  output strobe_t     strobes,
  output logic        isRead,
  output logic        isAccess
);

  assign isAccess = rdEn | wrEn;
  assign isRead   = rdEn & ~wrEn;

  always_comb begin
    region = RG_NONE;
    if (addr[15])                         region = RG_FIX_ROM;
    else if (addr[15:14] == 2'b01)        region = RG_BANK_ROM;
    else if (addr[15:12] == 4'h0)         region = RG_WRAM;
    else if (addr[15:11] == 5'b00010)     region = RG_WIN_A;
    else if (addr[15:11] == 5'b00011)     region = RG_WIN_B;
    else if (addr[15:3]  == 13'h0400)     region = RG_SPR_REG;
    else if (addr[15:10] == 6'b001001)    region = RG_SPR_RAM;
    else if (addr[15:11] == 5'b00101)     region = RG_ZOOM_B;
  end

  always_comb begin
    strobes.loadBank  = wrEn && (addr == ADR_BANK_REG);
    strobes.loadVideo = wrEn && (addr == ADR_VID_REG);
    strobes.sndCmd    = wrEn && (addr == ADR_SND_CMD);
    strobes.sndIrq    = wrEn && (addr == ADR_SND_IRQ);
    strobes.wdogKick  = wrEn && (addr == ADR_WDOG);
  end

endmodule

// File: rtl/map_datapath.sv
module map_datapath
  import mapdec_pkg::*;
#(
  parameter int BANK_BITS = 5,
  parameter int WIN_BITS  = 14,
  parameter int BASE_PAGE = 4,
  parameter int DATA_W    = 8,
  localparam int PAGE_W   = BANK_BITS + 1,
  localparam int ROM_AW   = PAGE_W + WIN_BITS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [WIN_BITS-1:0] winOffset,
  input  region_e             region,
  input  strobe_t             strobes,
  input  logic                isRead,
  input  logic                isAccess,
  output logic [NUM_CS-1:0]   chipSel,
  output logic [ROM_AW-1:0]   romAddr,
  output logic                sndLatchWr,
  output logic                sndIrqPulse,
  output logic                wdogKick,
  output logic [1:0]          coinCount,
  output logic                openBusEn
);

  logic [DATA_W-1:0] bankReg;
  logic [DATA_W-1:0] videoReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankReg  <= '0;
      videoReg <= '0;
    end else begin
      if (strobes.loadBank)  bankReg  <= wrData;
      if (strobes.loadVideo) videoReg <= wrData;
    end
  end

  logic winSwap;
  logic romRead;
  logic [PAGE_W-1:0] pageNum;

  assign winSwap = bankReg[WIN_SWAP_BIT];
  assign romRead = videoReg[ROM_READ_BIT] & isRead;
  assign pageNum = {1'b0, bankReg[BANK_BITS-1:0]} + PAGE_W'(BASE_PAGE);
  assign romAddr = {pageNum, winOffset};

  // Each zoom engine port shares one reroute rule: reads may go to ROM.
  logic [1:0] zoomHit;
  logic [1:0] zoomPort;
  logic [1:0] zoomRom;
  assign zoomHit[0] = isAccess && (region == RG_WIN_A) && winSwap;
  assign zoomHit[1] = isAccess && (region == RG_ZOOM_B);

  for (genvar z = 0; z < 2; z++) begin : g_zoom
    assign zoomRom[z]  = zoomHit[z] & romRead;
    assign zoomPort[z] = zoomHit[z] & ~romRead;
  end

  always_comb begin
    chipSel = '0;
    chipSel[CS_WRAM]     = isAccess && (region == RG_WRAM);
    chipSel[CS_RAM_A]    = isAccess && (region == RG_WIN_A) && !winSwap;
    chipSel[CS_RAM_B]    = isAccess && (region == RG_WIN_B) && !winSwap;
    chipSel[CS_PALETTE]  = isAccess && (region == RG_WIN_B) && winSwap;
    chipSel[CS_SPR_REG]  = isAccess && (region == RG_SPR_REG);
    chipSel[CS_SPR_RAM]  = isAccess && (region == RG_SPR_RAM);
    chipSel[CS_ZOOM_A]   = zoomPort[0];
    chipSel[CS_ZOOM_B]   = zoomPort[1];
    chipSel[CS_ZROM_A]   = zoomRom[0];
    chipSel[CS_ZROM_B]   = zoomRom[1];
    chipSel[CS_BANK_ROM] = isRead && (region == RG_BANK_ROM);
    chipSel[CS_FIX_ROM]  = isRead && (region == RG_FIX_ROM);
  end

  assign openBusEn   = isRead && (chipSel == '0);
  assign sndLatchWr  = strobes.sndCmd;
  assign sndIrqPulse = strobes.sndIrq;
  assign wdogKick    = strobes.wdogKick;
  assign coinCount   = {videoReg[0], videoReg[1]};

endmodule

// File: rtl/board_addr_decoder.sv
module board_addr_decoder
  import mapdec_pkg::*;
#(
  parameter int BANK_BITS = 5,
  parameter int WIN_BITS  = 14,
  parameter int BASE_PAGE = 4,
  parameter int DATA_W    = 8,
  localparam int ROM_AW   = BANK_BITS + 1 + WIN_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       addr,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [NUM_CS-1:0] chipSel,
  output logic [ROM_AW-1:0] romAddr,
  output logic              sndLatchWr,
  output logic              sndIrqPulse,
  output logic              wdogKick,
  output logic [1:0]        coinCount,
  output logic              openBusEn
);

  region_e region;
  strobe_t strobes;
  logic    isRead;
  logic    isAccess;

  map_ctrl i_ctrl (
    .addr     (addr),
    .rdEn     (rdEn),
    .wrEn     (wrEn),
    .region   (region),
    .strobes  (strobes),
    .isRead   (isRead),
    .isAccess (isAccess)
  );

  map_datapath #(
    .BANK_BITS (BANK_BITS),
    .WIN_BITS  (WIN_BITS),
    .BASE_PAGE (BASE_PAGE),
    .DATA_W    (DATA_W)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .wrData      (wrData),
    .winOffset   (addr[WIN_BITS-1:0]),
    .region      (region),
    .strobes     (strobes),
    .isRead      (isRead),
    .isAccess    (isAccess),
    .chipSel     (chipSel),
    .romAddr     (romAddr),
    .sndLatchWr  (sndLatchWr),
    .sndIrqPulse (sndIrqPulse),
    .wdogKick    (wdogKick),
    .coinCount   (coinCount),
    .openBusEn   (openBusEn)
  );

endmodule

// File: rtl/decoder_checker.sv
module decoder_checker (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] addr,
  input logic        rdEn,
  input logic        wrEn,
  input logic [7:0]  wrData,
  input logic [11:0] chipSel,
  input logic [19:0] romAddr,
  input logic        sndLatchWr,
  input logic        sndIrqPulse,
  input logic        wdogKick,
  input logic [1:0]  coinCount,
  input logic        openBusEn
);

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rstN) $onehot0(chipSel)); // R11
  AST_CS_IDLE: assert property (@(posedge clk) disable iff (!rstN) (!rdEn && !wrEn) |-> chipSel == '0); // R11
  AST_BANK_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 16'h3002) |=> romAddr[19:14] == 6'({1'b0, $past(wrData[4:0])} + 6'd4)); // R3
  AST_COIN_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 16'h3003) |=> coinCount == {$past(wrData[0]), $past(wrData[1])}); // R6
  AST_OPEN_BUS: assert property (@(posedge clk) disable iff (!rstN) openBusEn |-> (rdEn && chipSel == '0)); // R10
  AST_SND_LATCH: assert property (@(posedge clk) disable iff (!rstN) sndLatchWr |-> (wrEn && addr == 16'h3000)); // R7
  AST_SND_IRQ: assert property (@(posedge clk) disable iff (!rstN) sndIrqPulse |-> (wrEn && addr == 16'h3001)); // R7
  AST_WDOG_KICK: assert property (@(posedge clk) disable iff (!rstN) wdogKick |-> (wrEn && addr == 16'h3300)); // R8
  AST_COIN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!(wrEn && addr == 16'h3003) && $past(rstN)) |=> $stable(coinCount)); // R6

endmodule

bind board_addr_decoder decoder_checker i_checker (
  .clk         (clk),
  .rstN        (rstN),
  .addr        (addr),
  .rdEn        (rdEn),
  .wrEn        (wrEn),
  .wrData      (wrData),
  .chipSel     (chipSel),
  .romAddr     (romAddr),
  .sndLatchWr  (sndLatchWr),
  .sndIrqPulse (sndIrqPulse),
  .wdogKick    (wdogKick),
  .coinCount   (coinCount),
  .openBusEn   (openBusEn)
);

// File: tb/test_board_addr_decoder.sv
module test_board_addr_decoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] addr = '0;
  logic        rdEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [11:0] chipSel;
  logic [19:0] romAddr;
  logic        sndLatchWr;
  logic        sndIrqPulse;
  logic        wdogKick;
  logic [1:0]  coinCount;
  logic        openBusEn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  board_addr_decoder i_board_addr_decoder (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData),
    .chipSel(chipSel), .romAddr(romAddr), .sndLatchWr(sndLatchWr),
    .sndIrqPulse(sndIrqPulse), .wdogKick(wdogKick), .coinCount(coinCount),
    .openBusEn(openBusEn)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (addr=%h rd=%0b wr=%0b)", tag, act, exp, addr, rdEn, wrEn);
    end
  endtask

  function automatic logic [11:0] expSel(input logic [15:0] a, input bit rd, input bit wr,
                                         input logic [7:0] bank, input logic [7:0] vid);
    logic [11:0] s;
    bit isRd;
    s = '0;
    isRd = rd && !wr;
    if (!(rd || wr)) return s;
    if (a < 16'h1000) s[0] = 1'b1;
    else if (a < 16'h1800) begin
      if (!bank[5]) s[1] = 1'b1;
      else if (isRd && vid[4]) s[8] = 1'b1;
      else s[3] = 1'b1;
    end
    else if (a < 16'h2000) begin
      if (bank[5]) s[4] = 1'b1; else s[2] = 1'b1;
    end
    else if (a <= 16'h2007) s[5] = 1'b1;
    else if (a >= 16'h2400 && a <= 16'h27FF) s[6] = 1'b1;
    else if (a >= 16'h2800 && a <= 16'h2FFF) begin
      if (isRd && vid[4]) s[9] = 1'b1; else s[7] = 1'b1;
    end
    else if (a >= 16'h4000 && a <= 16'h7FFF) s[10] = isRd;
    else if (a >= 16'h8000) s[11] = isRd;
    return s;
  endfunction

  function automatic string tagOf(input logic [15:0] a);
    if (a < 16'h1000) return "R2";
    if (a < 16'h2000) return "R4_R5";
    if (a < 16'h3000) return "R9_R5";
    if (a < 16'h4000) return "R10_R7_R8";
    if (a < 16'h8000) return "R3_R10";
    return "R2_R10";
  endfunction

  task automatic writeReg(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1; rdEn = 1'b0;
    @(posedge clk);
    #1 wrEn = 1'b0;
  endtask

  task automatic probe(input logic [15:0] a, input bit rd, input bit wr,
                       input logic [7:0] bank, input logic [7:0] vid);
    logic [11:0] es;
    logic [15:0] actV;
    logic [15:0] expV;
    @(negedge clk);
    addr = a; rdEn = rd; wrEn = wr; wrData = 8'hA5;
    #3;
    es = expSel(a, rd, wr, bank, vid);
    expV = {es, (rd && !wr && es == 0), (wr && a == 16'h3000), (wr && a == 16'h3001), (wr && a == 16'h3300)};
    actV = {chipSel, openBusEn, sndLatchWr, sndIrqPulse, wdogKick};
    check(tagOf(a), 32'(actV), 32'(expV));
    if (rd && !wr && a >= 16'h4000 && a <= 16'h7FFF)
      check("R3", 32'(romAddr), 32'h10000 + 32'(bank[4:0]) * 32'h4000 + 32'(a[13:0]));
    rdEn = 1'b0; wrEn = 1'b0;
  endtask

  logic [15:0] edges [26] = '{16'h0FFF, 16'h1000, 16'h17FF, 16'h1800, 16'h1FFF, 16'h2000,
                             16'h2007, 16'h2008, 16'h23FF, 16'h2400, 16'h27FF, 16'h2800,
                             16'h2FFF, 16'h3000, 16'h3001, 16'h3002, 16'h3003, 16'h3004,
                             16'h32FF, 16'h3300, 16'h3301, 16'h3FFF, 16'h4000, 16'h7FFF,
                             16'h8000, 16'hFFFF};

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    @(negedge clk);
    check("R1 coin", 32'(coinCount), 32'h0);
    probe(16'h4000, 1'b1, 1'b0, 8'h00, 8'h00);
    check("R1 romAddr", 32'(romAddr), 32'h10000);
    probe(16'h1000, 1'b1, 1'b0, 8'h00, 8'h00);
    probe(16'h1800, 1'b0, 1'b1, 8'h00, 8'h00);
    probe(16'h0000, 1'b0, 1'b0, 8'h00, 8'h00); // R11 idle

    // R6: coin counters under every bit pair
    for (int v = 0; v < 4; v++) begin
      writeReg(16'h3003, 8'(v));
      @(negedge clk);
      check("R6", 32'(coinCount), 32'({v[0], v[1]}));
    end

    // R3: every bank page, upper register bits set on odd banks
    for (int b = 0; b < 32; b++) begin
      logic [7:0] d;
      d = 8'(b) | (b[0] ? 8'hE0 : 8'h00);
      writeReg(16'h3002, d);
      probe(16'h4000 + 16'((b * 517) % 16384), 1'b1, 1'b0, d, 8'h03);
    end

    // R2 R4 R5 R7 R8 R9 R10 R11: sweep under all routing settings
    for (int cfg = 0; cfg < 4; cfg++) begin
      logic [7:0] bk;
      logic [7:0] vd;
      bk = (cfg[0] ? 8'h20 : 8'h00) | 8'h03;
      vd = cfg[1] ? 8'h10 : 8'h00;
      writeReg(16'h3002, bk);
      writeReg(16'h3003, vd);
      for (int i = 0; i < 1024; i++) begin
        logic [15:0] a;
        a = 16'(i * 64 + (i % 64));
        probe(a, 1'b1, 1'b0, bk, vd);
        probe(a, 1'b0, 1'b1, bk, vd);
      end
      foreach (edges[k]) begin
        probe(edges[k], 1'b1, 1'b0, bk, vd);
        probe(edges[k], 1'b0, 1'b1, bk, vd);
        probe(edges[k], 1'b1, 1'b1, bk, vd); // R11 write wins
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(64'd20 * 64'd200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule